// File: doc/BRIEF.md
# Drift-Compensated Time-of-Day Counter

This block keeps a 64-bit nanosecond time value for a network timestamping unit. A tick strobe marks each 16 ns quantum, and on every tick the count moves forward by 16. Frequency error is trimmed by a period, step and direction triplet instead of a fractional addend. Software writes a period counted in ticks, a step of up to 7 ns and a direction. Once each period, the tick adds 16 plus the step or 16 minus the step.

Software uses a small register port. It can stop the counter, preset it in two 32-bit halves and start it again. It can hold the drift logic in reset while the triplet is rewritten. It reads the time as a low word followed by a high word. Reading the low word captures the high half, so the two words belong to the same instant.

Top module: `tod_drift_counter`

## Requirements
- R1: After reset the time is 0, the counter is running, the drift configuration word reads 0 and the drift-reset register reads 0.
- R2: On each tick while running, with no correction due, the time grows by exactly 16.
- R3: A write of 2 to the control register (address 0) stops the counter and a write of 4 restarts it. Any other value written there is ignored. Ticks that arrive while stopped leave the time unchanged.
- R4: While stopped, writes to address 1 and address 2 preset the low and high 32-bit halves of the time. While running, these writes are ignored.
- R5: The drift word (address 3) holds the period P in bits 27:0, the step M in bits 30:28 and the direction in bit 31 (0 adds, 1 subtracts). With a nonzero P, every P-th tick after drift-reset release advances the time by 16+M or 16-M.
- R6: A period field of 0, which includes an all-zero drift word, applies no correction.
- R7: Bit 0 of the drift-reset register (address 4) reads back its written value. While it is 1, the period count is held at zero and no correction is applied. Counting starts fresh when it returns to 0.
- R8: A read of address 5 returns time bits 31:0 and captures bits 63:32. A later read of address 6 returns the captured half, even if the time has moved since.
- R9: Read data appears on rd_data_o in the cycle after rd_en_i. Address 3 returns the drift word and address 0 returns the run state in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per 16 ns quantum |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data, registered |

## Verification
A write or a tick strobe takes effect at the clock edge where it is high, so the changed state can be read one edge later. Read data is registered and is due one edge after the read strobe. The bench raises each strobe for exactly one edge and samples rd_data_o at the falling edge that follows the capturing edge. The expected times are sums of 16 per tick plus or minus the step at each counted boundary, worked out from the tick count and the programmed period.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int PERIOD_W = 28;
  localparam int MAG_W    = 3;

  typedef enum logic [2:0] {
    A_CTRL      = 3'd0,
    A_LOAD_LO   = 3'd1,
    A_LOAD_HI   = 3'd2,
    A_DRIFT_CFG = 3'd3,
    A_DRIFT_RST = 3'd4,
    A_TIME_LO   = 3'd5,
    A_TIME_HI   = 3'd6
  } reg_addr_e;

  localparam logic [31:0] CMD_PAUSE  = 32'd2;
  localparam logic [31:0] CMD_RESUME = 32'd4;

  typedef struct packed {
    logic                dir;     // 1: subtract
    logic [MAG_W-1:0]    mag;
    logic [PERIOD_W-1:0] period;
  } drift_cfg_t;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_addr_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              running_o,
  output drift_cfg_t        cfg_o,
  output logic              drift_rst_o,
  output logic              load_lo_we_o,
  output logic              load_hi_we_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              running_q;
  drift_cfg_t        cfg_q;
  logic              drift_rst_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] rd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q   <= 1'b1;
      cfg_q       <= '0;
      drift_rst_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTRL: begin
          if (wr_data_i == CMD_PAUSE)       running_q <= 1'b0;
          else if (wr_data_i == CMD_RESUME) running_q <= 1'b1;
        end
        A_DRIFT_CFG: cfg_q       <= drift_cfg_t'(wr_data_i);
        A_DRIFT_RST: drift_rst_q <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q  <= '0;
      rd_data_q <= '0;
    end else if (rd_en_i) begin
      unique case (rd_addr_i)
        A_CTRL:      rd_data_q <= DATA_W'(running_q);
        A_DRIFT_CFG: rd_data_q <= DATA_W'(cfg_q);
        A_DRIFT_RST: rd_data_q <= DATA_W'(drift_rst_q);
        A_TIME_LO: begin
          rd_data_q <= time_i[DATA_W-1:0];
          shadow_q  <= time_i[TIME_W-1:DATA_W];
        end
        A_TIME_HI:   rd_data_q <= shadow_q;
        default:     rd_data_q <= '0;
      endcase
    end
  end

  assign running_o    = running_q;
  assign cfg_o        = cfg_q;
  assign drift_rst_o  = drift_rst_q;
  assign load_lo_we_o = wr_en_i && (wr_addr_i == A_LOAD_LO);
  assign load_hi_we_o = wr_en_i && (wr_addr_i == A_LOAD_HI);
  assign load_data_o  = wr_data_i;
  assign rd_data_o    = rd_data_q;

  p_pause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_CTRL && wr_data_i == CMD_PAUSE) |=> !running_o);
  p_resume_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_CTRL && wr_data_i == CMD_RESUME) |=> running_o);
  p_shadow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == A_TIME_LO) |=> shadow_q == $past(time_i[TIME_W-1:DATA_W]));
endmodule

// File: rtl/tod_drift.sv
module tod_drift
  import tod_pkg::*;
#(
  parameter int TICK_NS = 16,
  parameter int STEP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  drift_cfg_t        cfg_i,
  input  logic              drift_rst_i,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] BASE = STEP_W'(TICK_NS);

  logic [PERIOD_W-1:0] cnt_q;
  logic                en;
  logic                boundary;

  assign en       = !drift_rst_i && (cfg_i.period != '0);
  assign boundary = en && (cnt_q >= cfg_i.period - PERIOD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en)               cnt_q <= '0;
    else if (adv_i) cnt_q <= boundary ? '0 : cnt_q + PERIOD_W'(1);
  end

  always_comb begin
    step_o = BASE;
    if (boundary) begin
      if (cfg_i.dir) step_o = BASE - STEP_W'(cfg_i.mag);
      else           step_o = BASE + STEP_W'(cfg_i.mag);
    end
  end

  p_cnt_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drift_rst_i |=> cnt_q == '0);
  p_no_corr_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drift_rst_i |-> step_o == BASE);
  p_no_corr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.period == '0) |-> step_o == BASE);
endmodule

// File: rtl/tod_time.sv
module tod_time #(
  parameter int DATA_W  = 32,
  parameter int STEP_W  = 8,
  parameter int TICK_NS = 16,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              running_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              load_lo_we_i,
  input  logic              load_hi_we_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
    end else if (!running_i) begin
      if (load_lo_we_i) time_q[DATA_W-1:0]      <= load_data_i;
      if (load_hi_we_i) time_q[TIME_W-1:DATA_W] <= load_data_i;
    end else if (adv_i) begin
      time_q <= time_q + TIME_W'(step_i);
    end
  end

  assign time_o = time_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_i && !load_lo_we_i && !load_hi_we_i) |=> $stable(time_q));
  p_no_load_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && !adv_i) |=> $stable(time_q));
  p_step_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && adv_i) |=>
      ((time_q - $past(time_q)) >= TIME_W'(TICK_NS - 7)) &&
      ((time_q - $past(time_q)) <= TIME_W'(TICK_NS + 7)));
endmodule

// File: rtl/tod_drift_counter.sv
module tod_drift_counter
  import tod_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TICK_NS = 16,
  parameter int STEP_W  = 8,
  localparam int TIME_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              running;
  drift_cfg_t        cfg;
  logic              drift_rst;
  logic              load_lo_we, load_hi_we;
  logic [DATA_W-1:0] load_data;
  logic [TIME_W-1:0] time_val;
  logic [STEP_W-1:0] step;
  logic              adv;

  assign adv = tick_i && running;

  tod_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_en_i, .rd_addr_i,
    .time_i(time_val), .running_o(running), .cfg_o(cfg), .drift_rst_o(drift_rst),
    .load_lo_we_o(load_lo_we), .load_hi_we_o(load_hi_we),
    .load_data_o(load_data), .rd_data_o
  );

  tod_drift #(.TICK_NS(TICK_NS), .STEP_W(STEP_W)) u_drift (
    .clk_i, .rst_ni, .adv_i(adv), .cfg_i(cfg), .drift_rst_i(drift_rst),
    .step_o(step)
  );

  tod_time #(.DATA_W(DATA_W), .STEP_W(STEP_W), .TICK_NS(TICK_NS)) u_time (
    .clk_i, .rst_ni, .adv_i(adv), .running_i(running), .step_i(step),
    .load_lo_we_i(load_lo_we), .load_hi_we_i(load_hi_we),
    .load_data_i(load_data), .time_o(time_val)
  );

  p_plain_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && (drift_rst || cfg.period == '0)) |=>
      time_val == $past(time_val) + TIME_W'(TICK_NS));
endmodule

// File: tb/sim_tod_drift_counter.sv
module sim_tod_drift_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  tod_drift_counter u0 (.*);

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i); rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i); rd_en_i = 1'b0; d = rd_data_o;
  endtask

  task automatic rd_time(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd5, lo); rd(3'd6, hi); t = {hi, lo};
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk_i); tick_i = 1'b1; end
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic setup_drift(input logic [31:0] cfg_word);
    logic [31:0] v;
    wr(3'd0, 32'd2);
    wr(3'd4, 32'd1);
    rd(3'd4, v); chk("R7 drift reset readback 1", v, 1);
    wr(3'd3, cfg_word);
    wr(3'd1, 32'd0); wr(3'd2, 32'd0);
    wr(3'd4, 32'd0);
    rd(3'd4, v); chk("R7 drift reset readback 0", v, 0);
    wr(3'd0, 32'd4);
  endtask

  task automatic t_reset;
    logic [31:0] v; logic [63:0] t;
    rd_time(t);  chk("R1 time after reset", t, 0);
    rd(3'd0, v); chk("R1 running after reset", v, 1);
    rd(3'd3, v); chk("R1 drift word after reset", v, 0);
    rd(3'd4, v); chk("R1 drift reset after reset", v, 0);
  endtask

  task automatic t_plain;
    logic [63:0] t;
    ticks(10); rd_time(t); chk("R2 ten plain ticks", t, 160);
  endtask

  task automatic t_pause;
    logic [63:0] t; logic [31:0] v;
    wr(3'd0, 32'd2); rd(3'd0, v); chk("R3 stopped state", v, 0);
    ticks(5); rd_time(t); chk("R3 ticks while stopped", t, 160);
    wr(3'd0, 32'd3); rd(3'd0, v); chk("R3 other control value ignored", v, 0);
    wr(3'd0, 32'd4); ticks(1); rd_time(t); chk("R3 resumed", t, 176);
    wr(3'd0, 32'd6); rd(3'd0, v); chk("R3 other value while running", v, 1);
  endtask

  task automatic t_load;
    logic [63:0] t;
    wr(3'd1, 32'h1234); wr(3'd2, 32'h55);
    rd_time(t); chk("R4 preset ignored while running", t, 176);
    wr(3'd0, 32'd2); wr(3'd1, 32'hFFFF_FFF0); wr(3'd2, 32'h1);
    rd_time(t); chk("R4 preset while stopped", t, 64'h1_FFFF_FFF0);
    wr(3'd0, 32'd4); ticks(1);
    rd_time(t); chk("R4 carry into high half", t, 64'h2_0000_0000);
  endtask

  task automatic t_shadow;
    logic [31:0] lo, hi; logic [63:0] t;
    wr(3'd0, 32'd2); wr(3'd1, 32'hFFFF_FFF0); wr(3'd2, 32'h0); wr(3'd0, 32'd4);
    rd(3'd5, lo); chk("R8 low word", lo, 32'hFFFF_FFF0);
    ticks(1);
    rd(3'd6, hi); chk("R8 high word is captured half", hi, 0);
    rd_time(t); chk("R8 fresh coherent read", t, 64'h1_0000_0000);
  endtask

  task automatic t_drift_add;
    logic [31:0] v; logic [63:0] t;
    setup_drift({1'b0, 3'd5, 28'd4});
    rd(3'd3, v); chk("R9 drift word readback", v, {1'b0, 3'd5, 28'd4});
    ticks(8); rd_time(t); chk("R5 add 5 every 4 ticks", t, 138);
  endtask

  task automatic t_drift_sub;
    logic [63:0] t;
    setup_drift({1'b1, 3'd7, 28'd3});
    ticks(6); rd_time(t); chk("R5 subtract 7 every 3 ticks", t, 82);
  endtask

  task automatic t_drift_every;
    logic [63:0] t;
    setup_drift({1'b0, 3'd3, 28'd1});
    ticks(4); rd_time(t); chk("R5 period 1 corrects each tick", t, 76);
  endtask

  task automatic t_drift_zero;
    logic [63:0] t;
    setup_drift({1'b0, 3'd7, 28'd0});
    ticks(6); rd_time(t); chk("R6 period 0 no correction", t, 96);
    setup_drift(32'd0);
    ticks(6); rd_time(t); chk("R6 zero word no correction", t, 96);
  endtask

  task automatic t_drift_hold;
    logic [63:0] t;
    setup_drift({1'b0, 3'd5, 28'd2});
    wr(3'd4, 32'd1);
    ticks(8); rd_time(t); chk("R7 no correction in drift reset", t, 128);
    wr(3'd4, 32'd0);
    ticks(1); rd_time(t); chk("R7 count restarts after release", t, 144);
    ticks(1); rd_time(t); chk("R7 first boundary after release", t, 165);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_plain();
    t_pause();
    t_load();
    t_shadow();
    t_drift_add();
    t_drift_sub();
    t_drift_every();
    t_drift_zero();
    t_drift_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule